// File: doc/BRIEF.md
# Bunch-Crossing Hit Timestamp Store

This block keeps a short, time-ordered record of hits for every pixel of a small sensor array. Each record is the number of the bunch crossing in which the hit occurred. A shared bunch-crossing counter bus is the source of that number. While the accelerator delivers a bunch train, each pixel writes the crossing number into its own small buffer whenever its comparator fires. When a buffer is full, any further hit in that pixel is discarded, and a sticky overflow indication is raised.

Once the train has ended, a readout controller starts a scan of the array. The scan skips every pixel that holds no data. For each pixel that has data, it hands out one word per stored entry, oldest first. Each word carries the pixel's column, its row, its overflow bit and the timestamp. A new train wipes every buffer. If the scan had not emptied all buffers by then, a lost-data flag records it.

Top module: `bx_hit_store`

## Requirements
- R1: A hit sampled while the train is active stores the value on `bx_num` in that same clock cycle as a 14-bit timestamp in the hit pixel.
- R2: A pixel stores at most one timestamp per bunch crossing, however many clocks its hit input stays high. A hit still high when `bx_num` changes counts as a hit in the new crossing.
- R3: Hits sampled while `train_active` is low are ignored and store nothing.
- R4: Each pixel holds up to DEPTH entries (4 by default). Hits beyond that are dropped, and the earlier entries are kept. A dropped hit sets the pixel's sticky overflow bit, and `ovf_flag` is the OR of all pixel overflow bits.
- R5: The first clock with `train_active` high clears all entries and overflow bits. A hit sampled in that same clock is stored in the emptied buffer.
- R6: On that first train clock, `lost_flag` is loaded with 1 if any entry was still unread, and with 0 otherwise. It holds that value until the next train starts.
- R7: `rd_start` is ignored while the train is active. A train that starts in the middle of a scan ends the scan, and no further words are offered.
- R8: The readout word has the pixel overflow bit in bit 24, the column in bits 23:19, the row in bits 18:14 and the timestamp in bits 13:0.
- R9: A scan visits pixels row by row, starting at row 0 and column 0, with the column advancing fastest. Within a pixel the entries come out oldest first. A pixel with no entries produces no word.
- R10: While `rd_valid` is high and `rd_ack` is low, the word is held unchanged. A clock with both high consumes the word.
- R11: When a scan completes, `rd_done` is high for exactly one clock. During a scan, `rd_count` shows the number of entries left in the pixel under the scan position, counting the word being offered. Outside a scan it reads 0.
- R12: `hit_present` is high exactly when at least one pixel holds an unread entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_active | input | 1 | High during a bunch train |
| bx_num | input | 14 | Shared bunch-crossing number |
| hit_in | input | NCOL*NROW | Comparator hit, one bit per pixel, index row*NCOL+col |
| rd_start | input | 1 | Starts an array scan between trains |
| rd_ack | input | 1 | Consumes the offered word |
| rd_valid | output | 1 | A word is offered |
| rd_word | output | 25 | Overflow bit, column, row, timestamp |
| rd_count | output | clog2(DEPTH+1) | Entries left in the current scan pixel |
| rd_done | output | 1 | One-clock pulse at the end of a scan |
| hit_present | output | 1 | Some pixel holds unread entries |
| ovf_flag | output | 1 | Some pixel dropped a hit in this train |
| lost_flag | output | 1 | Unread entries were wiped at the last train start |

## Verification
The block is exercised with several kinds of stimulus, and each separates a different fault.
- A sparse set of single-clock hits in a few scattered pixels, with the crossing number wrapping past its maximum, checks that timestamps are placed in the right slot and that the scan order and the skipping of empty pixels are correct.
- A hit held for several clocks, and then carried across a change of crossing, tells the once-per-crossing rule apart from plain level sampling.
- Bursts longer than the buffer depth check that early entries survive and that overflow is reported, both in the flag and in the word bit.
- Hits and scan requests outside their allowed phase, a hit in the very first train clock, and a scan cut short by a new train check the phase rules and the lost-data flag.
- Several random trains with irregular acknowledge stalls compare the full word stream against a reference queue.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int TS_W   = 14;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 1 + 2 * ADDR_W + TS_W;

  typedef logic [TS_W-1:0] ts_t;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_SCAN = 1'b1
  } scan_st_e;

  typedef struct packed {
    logic              ovf;
    logic [ADDR_W-1:0] col;
    logic [ADDR_W-1:0] row;
    ts_t               ts;
  } rd_word_t;
endpackage

// File: rtl/bxs_pixel.sv
module bxs_pixel
  import bxs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap_en,
  input  logic             bx_new,
  input  logic             hit,
  input  ts_t              bx_num,
  input  logic             pop,
  output ts_t              head_ts,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  ts_t              mem_q [DEPTH];
  logic [CNT_W-1:0] wr_q, rd_q, wr_n, rd_n, wr_base, rd_base;
  logic             ovf_q, ovf_n, seen_q, seen_n, seen_base;
  logic             take, room, do_pop;
  logic [DEPTH-1:0] wen;

  // next-state: a train start empties the buffer before this cycle's hit
  always_comb begin
    wr_base   = clr ? '0 : wr_q;
    rd_base   = clr ? '0 : rd_q;
    seen_base = clr ? 1'b0 : (seen_q & ~bx_new);
    take      = cap_en & hit & ~seen_base;
    room      = (wr_base < FULL);
    do_pop    = pop & ~cap_en & (rd_q < wr_q);
    wr_n      = wr_base + CNT_W'(take & room);
    rd_n      = rd_base + CNT_W'(do_pop);
    ovf_n     = (ovf_q & ~clr) | (take & ~room);
    seen_n    = seen_base | take;
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_wen
      assign wen[e] = take & room & (wr_base == CNT_W'(e));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      ovf_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      ovf_q  <= ovf_n;
      seen_q <= seen_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wen[e]) mem_q[e] <= bx_num;
      end
    end
  end

  always_comb begin
    head_ts = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_q == CNT_W'(e)) head_ts = mem_q[e];
    end
  end

  assign cnt = wr_q - rd_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/bxs_phase.sv
module bxs_phase
  import bxs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic train_active,
  input  ts_t  bx_num,
  input  logic any_unread,
  output logic train_start,
  output logic bx_new,
  output logic lost_flag
);
  logic train_q;
  ts_t  bx_q;
  logic lost_q, lost_n;

  always_comb begin
    train_start = train_active & ~train_q;
    bx_new      = (bx_num != bx_q);
    lost_n      = train_start ? any_unread : lost_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      train_q <= 1'b0;
      bx_q    <= '0;
      lost_q  <= 1'b0;
    end else begin
      train_q <= train_active;
      bx_q    <= bx_num;
      lost_q  <= lost_n;
    end
  end

  assign lost_flag = lost_q;
endmodule

// File: rtl/bxs_scan.sv
module bxs_scan
  import bxs_pkg::*;
#(
  parameter int NCOL  = 4,
  parameter int NROW  = 4,
  parameter int CNT_W = 3,
  parameter int COL_W = $clog2(NCOL),
  parameter int ROW_W = $clog2(NROW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_active,
  input  logic             rd_start,
  input  logic             rd_ack,
  input  logic [CNT_W-1:0] cur_cnt,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             scanning,
  output logic             rd_valid,
  output logic             pop_req,
  output logic             rd_done
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(NCOL - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NROW - 1);

  scan_st_e         st_q, st_n;
  logic [COL_W-1:0] col_q, col_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic             done_q, done_n;
  logic             at_last, empty;

  always_comb begin
    st_n     = st_q;
    col_n    = col_q;
    row_n    = row_q;
    done_n   = 1'b0;
    at_last  = (col_q == COL_LAST) && (row_q == ROW_LAST);
    empty    = (cur_cnt == '0);
    rd_valid = (st_q == SC_SCAN) && !train_active && !empty;
    pop_req  = rd_valid & rd_ack;
    unique case (st_q)
      SC_IDLE: begin
        if (rd_start && !train_active) begin
          st_n  = SC_SCAN;
          col_n = '0;
          row_n = '0;
        end
      end
      SC_SCAN: begin
        if (train_active) begin
          st_n = SC_IDLE;
        end else if (empty) begin
          if (at_last) begin
            st_n   = SC_IDLE;
            done_n = 1'b1;
          end else if (col_q == COL_LAST) begin
            col_n = '0;
            row_n = row_q + ROW_W'(1);
          end else begin
            col_n = col_q + COL_W'(1);
          end
        end
      end
      default: st_n = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_IDLE;
      col_q  <= '0;
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      col_q  <= col_n;
      row_q  <= row_n;
      done_q <= done_n;
    end
  end

  assign col      = col_q;
  assign row      = row_q;
  assign scanning = (st_q == SC_SCAN);
  assign rd_done  = done_q;
endmodule

// File: rtl/bx_hit_store.sv
module bx_hit_store
  import bxs_pkg::*;
#(
  parameter int NCOL  = 4,
  parameter int NROW  = 4,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         train_active,
  input  logic [TS_W-1:0]              bx_num,
  input  logic [NCOL*NROW-1:0]         hit_in,
  input  logic                         rd_start,
  input  logic                         rd_ack,
  output logic                         rd_valid,
  output logic [WORD_W-1:0]            rd_word,
  output logic [$clog2(DEPTH+1)-1:0]   rd_count,
  output logic                         rd_done,
  output logic                         hit_present,
  output logic                         ovf_flag,
  output logic                         lost_flag
);
  localparam int NPIX  = NCOL * NROW;
  localparam int PIX_W = $clog2(NPIX);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int COL_W = $clog2(NCOL);
  localparam int ROW_W = $clog2(NROW);

  ts_t              head_arr [NPIX];
  logic [CNT_W-1:0] cnt_arr  [NPIX];
  logic [NPIX-1:0]  ovf_vec, nz_vec, pop_vec;
  logic             train_start, bx_new, any_unread;
  logic [COL_W-1:0] scan_col;
  logic [ROW_W-1:0] scan_row;
  logic [PIX_W-1:0] idx;
  logic [CNT_W-1:0] cur_cnt;
  logic             scanning, pop_req;
  rd_word_t         word;

  bxs_phase u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .train_active (train_active),
    .bx_num       (bx_num),
    .any_unread   (any_unread),
    .train_start  (train_start),
    .bx_new       (bx_new),
    .lost_flag    (lost_flag)
  );

  generate
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
      bxs_pixel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (train_start),
        .cap_en  (train_active),
        .bx_new  (bx_new),
        .hit     (hit_in[p]),
        .bx_num  (bx_num),
        .pop     (pop_vec[p]),
        .head_ts (head_arr[p]),
        .cnt     (cnt_arr[p]),
        .ovf     (ovf_vec[p])
      );
      assign nz_vec[p]  = (cnt_arr[p] != '0);
      assign pop_vec[p] = pop_req & (idx == PIX_W'(p));
    end
  endgenerate

  bxs_scan #(.NCOL(NCOL), .NROW(NROW), .CNT_W(CNT_W)) u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .train_active (train_active),
    .rd_start     (rd_start),
    .rd_ack       (rd_ack),
    .cur_cnt      (cur_cnt),
    .col          (scan_col),
    .row          (scan_row),
    .scanning     (scanning),
    .rd_valid     (rd_valid),
    .pop_req      (pop_req),
    .rd_done      (rd_done)
  );

  always_comb begin
    idx      = PIX_W'(scan_row) * PIX_W'(NCOL) + PIX_W'(scan_col);
    cur_cnt  = cnt_arr[idx];
    word.ovf = ovf_vec[idx];
    word.col = ADDR_W'(scan_col);
    word.row = ADDR_W'(scan_row);
    word.ts  = head_arr[idx];
  end

  assign any_unread  = |nz_vec;
  assign hit_present = any_unread;
  assign ovf_flag    = |ovf_vec;
  assign rd_word     = word;
  assign rd_count    = scanning ? cur_cnt : '0;
endmodule

// File: rtl/bx_hit_store_chk.sv
module bx_hit_store_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int WORD_W = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              train_active,
  input logic              rd_valid,
  input logic              rd_ack,
  input logic [WORD_W-1:0] rd_word,
  input logic [CNT_W-1:0]  rd_count,
  input logic              rd_done,
  input logic              hit_present,
  input logic              ovf_flag,
  input logic              lost_flag
);
  a_r3_capture_in_train: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_present) |-> $past(train_active));

  a_r4_ovf_in_train: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(train_active));

  a_r5_ovf_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> ($past(train_active) && !$past(train_active, 2)));

  a_r6_lost_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lost_flag) |-> ($past(train_active) && !$past(train_active, 2)));

  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ack && !train_active) |=> (train_active || (rd_valid && $stable(rd_word))));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= CNT_W'(DEPTH));

  a_r11_count_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_count != '0));

  a_r12_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> hit_present);
endmodule

bind bx_hit_store bx_hit_store_chk #(
  .DEPTH (DEPTH),
  .CNT_W ($clog2(DEPTH + 1)),
  .WORD_W(bxs_pkg::WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .train_active (train_active),
  .rd_valid     (rd_valid),
  .rd_ack       (rd_ack),
  .rd_word      (rd_word),
  .rd_count     (rd_count),
  .rd_done      (rd_done),
  .hit_present  (hit_present),
  .ovf_flag     (ovf_flag),
  .lost_flag    (lost_flag)
);

// File: tb/bx_hit_store_tb.sv
module bx_hit_store_tb;
  localparam int NCOL = 4, NROW = 4, DEPTH = 4, NPIX = 16, CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst_n, train_active, rd_start, rd_ack;
  logic [13:0]      bx_num;
  logic [NPIX-1:0]  hit_in;
  logic             rd_valid, rd_done, hit_present, ovf_flag, lost_flag;
  logic [24:0]      rd_word;
  logic [CNT_W-1:0] rd_count;

  always #10 clk = ~clk;

  bx_hit_store #(.NCOL(NCOL), .NROW(NROW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .train_active(train_active), .bx_num(bx_num),
    .hit_in(hit_in), .rd_start(rd_start), .rd_ack(rd_ack), .rd_valid(rd_valid),
    .rd_word(rd_word), .rd_count(rd_count), .rd_done(rd_done),
    .hit_present(hit_present), .ovf_flag(ovf_flag), .lost_flag(lost_flag)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [13:0] bx_cur;
  logic [13:0] m_ts [NPIX][DEPTH];
  int          m_cnt [NPIX];
  bit          m_ovf [NPIX];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic bit m_any();
    for (int p = 0; p < NPIX; p++) if (m_cnt[p] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_push(input logic [NPIX-1:0] mask);
    for (int p = 0; p < NPIX; p++) begin
      if (mask[p]) begin
        if (m_cnt[p] < DEPTH) begin
          m_ts[p][m_cnt[p]] = bx_cur;
          m_cnt[p]++;
        end else m_ovf[p] = 1'b1;
      end
    end
  endtask

  // starts a train; mask is hit in the very first train clock (R5)
  task automatic train_begin(input logic [NPIX-1:0] mask);
    bit exp_lost;
    exp_lost = m_any();
    for (int p = 0; p < NPIX; p++) begin m_cnt[p] = 0; m_ovf[p] = 1'b0; end
    bx_cur++;
    train_active = 1'b1; bx_num = bx_cur; hit_in = mask;
    m_push(mask);
    @(negedge clk);
    hit_in = '0;
    chk("R6", "lost_flag at train start", 32'(lost_flag), 32'(exp_lost));
    chk("R5", "ovf_flag after clear", 32'(ovf_flag), 32'(0));
    chk("R12", "hit_present after clear", 32'(hit_present), 32'(mask != '0));
  endtask

  task automatic train_end();
    train_active = 1'b0; hit_in = '0;
    @(negedge clk);
  endtask

  task automatic bunch(input logic [NPIX-1:0] mask, input int nclk);
    bx_cur++;
    bx_num = bx_cur; hit_in = mask;
    m_push(mask);
    repeat (nclk) @(negedge clk);
  endtask

  task automatic readout(input bit stall);
    logic [24:0] q_w[$];
    int          q_c[$];
    bit          got_done, ack;
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++)
        for (int e = 0; e < m_cnt[r*NCOL+c]; e++) begin
          q_w.push_back({m_ovf[r*NCOL+c], 5'(c), 5'(r), m_ts[r*NCOL+c][e]});
          q_c.push_back(m_cnt[r*NCOL+c] - e);
        end
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    got_done = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (rd_done) begin got_done = 1'b1; break; end
      if (rd_valid) begin
        if (q_w.size() == 0) begin
          chk("R9", "unexpected word", 32'(rd_word), 32'(0));
          ack = 1'b1;
        end else begin
          chk("R8", "readout word", 32'(rd_word), 32'(q_w[0]));
          chk("R11", "rd_count", 32'(rd_count), 32'(q_c[0]));
          ack = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
          if (ack) begin void'(q_w.pop_front()); void'(q_c.pop_front()); end
        end
        rd_ack = ack;
      end else rd_ack = 1'b0;
      @(negedge clk);
    end
    rd_ack = 1'b0;
    chk("R11", "rd_done seen", 32'(got_done), 32'(1));
    chk("R9", "words left unread", 32'(q_w.size()), 32'(0));
    chk("R12", "hit_present after scan", 32'(hit_present), 32'(0));
    chk("R11", "rd_count idle", 32'(rd_count), 32'(0));
    for (int p = 0; p < NPIX; p++) m_cnt[p] = 0;
  endtask

  task automatic test_reset();
    chk("R11", "rd_valid at reset", 32'(rd_valid), 32'(0));
    chk("R12", "hit_present at reset", 32'(hit_present), 32'(0));
    chk("R4", "ovf_flag at reset", 32'(ovf_flag), 32'(0));
    chk("R6", "lost_flag at reset", 32'(lost_flag), 32'(0));
    chk("R11", "rd_count at reset", 32'(rd_count), 32'(0));
    chk("R11", "rd_done at reset", 32'(rd_done), 32'(0));
  endtask

  task automatic test_basic();  // R1 R9 R12, crossing number wraps
    bx_cur = 14'h3FFC;
    train_begin('0);
    bunch(16'h0001, 1);
    bunch(16'h0000, 1);
    bunch(16'h8020, 1);
    bunch(16'h8004, 1);
    bunch(16'h0000, 1);
    chk("R12", "hit_present during train", 32'(hit_present), 32'(1));
    chk("R1", "no overflow", 32'(ovf_flag), 32'(0));
    train_end();
    readout(1'b0);
  endtask

  task automatic test_hold();  // R2
    train_begin('0);
    bunch(16'h0008, 4);
    bunch(16'h0008, 2);
    bunch(16'h0000, 1);
    train_end();
    readout(1'b0);
  endtask

  task automatic test_gate();  // R3 R7
    for (int i = 0; i < 3; i++) begin
      bx_cur++; bx_num = bx_cur; hit_in = 16'h0080;
      @(negedge clk);
    end
    hit_in = '0;
    @(negedge clk);
    chk("R3", "hit_present after idle hits", 32'(hit_present), 32'(0));
    train_begin('0);
    bunch(16'h0002, 1);
    bunch(16'h0000, 1);
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    chk("R7", "rd_valid during train", 32'(rd_valid), 32'(0));
    train_end();
    chk("R7", "no scan from start in train", 32'(rd_valid), 32'(0));
    @(negedge clk);
    chk("R7", "still no scan", 32'(rd_valid), 32'(0));
    readout(1'b0);
  endtask

  task automatic test_overflow();  // R4 R5 R6
    train_begin('0);
    for (int i = 0; i < 6; i++) bunch(16'h0200, 1);
    bunch(16'h0400, 1);
    bunch(16'h0400, 1);
    bunch(16'h0000, 1);
    chk("R4", "ovf_flag after burst", 32'(ovf_flag), 32'(1));
    train_end();
    readout(1'b1);
    chk("R4", "ovf_flag sticky after readout", 32'(ovf_flag), 32'(1));
    train_begin('0);
    train_end();
  endtask

  task automatic test_first_clock();  // R5 R6
    train_begin('0);
    bunch(16'h1000, 1);
    bunch(16'h0000, 1);
    train_end();
    train_begin(16'h0040);
    bunch(16'h0000, 1);
    train_end();
    readout(1'b0);
  endtask

  task automatic test_abort();  // R7 R6
    train_begin('0);
    bunch(16'h0011, 1);
    bunch(16'h0001, 1);
    bunch(16'h0000, 1);
    train_end();
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    chk("R9", "first word offered", 32'(rd_valid), 32'(1));
    chk("R8", "first word", 32'(rd_word), 32'({1'b0, 5'd0, 5'd0, m_ts[0][0]}));
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    m_ts[0][0] = m_ts[0][1];
    m_cnt[0]--;
    train_begin('0);
    chk("R7", "scan aborted by train", 32'(rd_valid), 32'(0));
    train_end();
    chk("R7", "no resume after abort", 32'(rd_valid), 32'(0));
    readout(1'b0);
  endtask

  task automatic test_random();  // R1 R2 R4 R9 R10
    for (int t = 0; t < 3; t++) begin
      train_begin('0);
      for (int b = 0; b < 400; b++) begin
        logic [NPIX-1:0] m;
        for (int p = 0; p < NPIX; p++) m[p] = ($urandom_range(0, 59) == 0);
        bunch(m, $urandom_range(1, 3));
      end
      bunch('0, 1);
      train_end();
      readout(1'b1);
    end
  endtask

  initial begin
    rst_n = 1'b0; train_active = 1'b0; rd_start = 1'b0; rd_ack = 1'b0;
    bx_num = '0; hit_in = '0; bx_cur = '0;
    for (int p = 0; p < NPIX; p++) begin m_cnt[p] = 0; m_ovf[p] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_hold();
    test_gate();
    test_overflow();
    test_first_clock();
    test_abort();
    test_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule